// File: doc/BRIEF.md
# Weight-Cached Systolic Multiply-Accumulate Array

This block is a two-dimensional grid of multiply-accumulate processing elements that computes one matrix-vector product per clock. It has `ROWS` rows (output channels) and `COLS` columns (vector length or kernel taps). Each element holds four resident 16-bit weights and multiplies the data word passing through it by the weight that the vector's bank index selects. It then adds the partial sum arriving from its left neighbour and forwards the total to its right neighbour.

The data word, the bank index and a valid flag travel down each column. Partial sums travel along each row, starting from a per-row bias. Input-side skew registers and output-side deskew registers let the caller present a whole vector in one cycle and receive the whole result vector in one later cycle.

A single-channel 1D convolution uses the same array. The kernels are stored as rows of a weight bank, and successive sliding windows of the input sequence are presented as back-to-back vectors. Because four banks stay resident, the four gate matrices of a recurrent cell can be loaded once and then selected per vector with no reload between time steps.

Top module: `wsys_array`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `out_valid` is 0 and `out_y` is all zero. After reset every cached weight in every bank is zero, so a vector sent before any load returns its bias unchanged.
- R2: Operands are 16-bit two's-complement with 11 fraction bits. Each element's product `x*w` is rounded by adding 2^10 and shifting right arithmetically by 11, which rounds halves toward +infinity. The rounded product is then clipped to [-32768, 32767].
- R3: The result for row r is the row bias plus the rounded products of columns 0, 1, ..., COLS-1, added in that order. The sum is clipped to [-32768, 32767] after every addition.
- R4: A vector presented with `in_valid` high in cycle T appears on all rows of `out_y` with `out_valid` high in cycle T+ROWS+COLS-1. `out_valid` is high in no other cycle.
- R5: A new vector can be accepted in every cycle, and back-to-back vectors produce back-to-back results in the same order.
- R6: Each element holds four weight banks. `in_bank` (0..3) is sampled with each vector and selects the bank for that vector only, so the bank may change between consecutive vectors.
- R7: With `ld_en` high, `ld_data` is written into bank `ld_bank` of the element at row `ld_row` and column `ld_col`, and is used by vectors presented from the next cycle on. No other bank and no other element changes. A load into one bank while vectors stream through another leaves their results unaffected.
- R8: Presenting the windows s[k..k+COLS-1] for k = 0, 1, 2, ... on consecutive cycles, with `in_x` lane c carrying s[k+c], yields on row r the convolution of the sequence with the kernel held in row r, one output per cycle.
- R9: Vector lane c is `in_x[16c+15:16c]`, row bias r is `in_bias[16r+15:16r]` and row result r is `out_y[16r+15:16r]`. With an all-zero data vector the output equals the bias whatever the weights.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Weight write strobe |
| ld_bank | input | 2 | Bank written by the load |
| ld_row | input | clog2(ROWS) | Row of the element written |
| ld_col | input | clog2(COLS) | Column of the element written |
| ld_data | input | 16 | Weight value to store |
| in_valid | input | 1 | A vector is presented this cycle |
| in_bank | input | 2 | Weight bank used by this vector |
| in_x | input | COLS*16 | Data vector, lane c at bits 16c+15:16c |
| in_bias | input | ROWS*16 | Per-row bias, row r at bits 16r+15:16r |
| out_valid | output | 1 | Result vector is present on out_y |
| out_y | output | ROWS*16 | Result vector, row r at bits 16r+15:16r |

## Verification
Every result vector is due exactly ROWS+COLS-1 cycles after the cycle in which its input was presented, which is 11 cycles for the 4x8 instance under test. Bank switches and weight loads add no cycles. The bench stamps each presented vector with its issue cycle and samples the outputs on the falling clock edge. It requires `out_valid` in exactly the stamped cycle plus the latency and compares every row value there. A valid flag that arrives early, late or with nothing outstanding counts as a failure. Loads are checked through later results only: a write in cycle t is first seen by a vector presented in cycle t+1.

// File: rtl/wsys_pkg.sv
`timescale 1ns/1ps
package wsys_pkg;
    localparam int DATA_W    = 16;
    localparam int FRAC_W    = 11;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int WIDE_W    = 2 * DATA_W + 2;

    typedef logic signed [DATA_W-1:0] fx_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam fx_t   FX_MAX    = fx_t'({1'b0, {(DATA_W-1){1'b1}}});
    localparam fx_t   FX_MIN    = fx_t'({1'b1, {(DATA_W-1){1'b0}}});
    localparam wide_t RND_HALF  = wide_t'(1) <<< (FRAC_W - 1);

    // word travelling down a column together with its control
    typedef struct packed {
        fx_t               data;
        logic [BANK_W-1:0] bank;
        logic              vld;
    } lane_t;

    function automatic fx_t fx_clip(input wide_t v);
        if (v > wide_t'(FX_MAX)) return FX_MAX;
        if (v < wide_t'(FX_MIN)) return FX_MIN;
        return fx_t'(v);
    endfunction

    // rounded, clipped fixed-point product
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        wide_t p;
        p = wide_t'(a) * wide_t'(b);
        p = (p + RND_HALF) >>> FRAC_W;
        return fx_clip(p);
    endfunction

    function automatic fx_t fx_add(input fx_t a, input fx_t b);
        return fx_clip(wide_t'(a) + wide_t'(b));
    endfunction
endpackage

// File: rtl/wsys_delay.sv
`timescale 1ns/1ps
module wsys_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[DEPTH-1];
endmodule

// File: rtl/wsys_pe.sv
`timescale 1ns/1ps
module wsys_pe
    import wsys_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  fx_t               wr_data,
    input  lane_t             lane_i,
    input  fx_t               psum_i,
    output fx_t               psum_o
);
    typedef struct packed {
        fx_t [NUM_BANKS-1:0] wbank;
        fx_t                 psum;
    } pe_state_t;

    pe_state_t st_d, st_q;
    fx_t       w_sel;

    always_comb begin
        st_d  = st_q;
        w_sel = st_q.wbank[lane_i.bank];
        if (wr_en) begin
            st_d.wbank[wr_bank] = wr_data;
        end
        // partial sum only moves with a live word, idle slots hold
        if (lane_i.vld) begin
            st_d.psum = fx_add(psum_i, fx_mul(lane_i.data, w_sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psum_o = st_q.psum;
endmodule

// File: rtl/wsys_array.sv
`timescale 1ns/1ps
module wsys_array
    import wsys_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_en,
    input  logic [BANK_W-1:0]      ld_bank,
    input  logic [ROW_W-1:0]       ld_row,
    input  logic [COL_W-1:0]       ld_col,
    input  logic [DATA_W-1:0]      ld_data,
    input  logic                   in_valid,
    input  logic [BANK_W-1:0]      in_bank,
    input  logic [COLS*DATA_W-1:0] in_x,
    input  logic [ROWS*DATA_W-1:0] in_bias,
    output logic                   out_valid,
    output logic [ROWS*DATA_W-1:0] out_y
);
    localparam int LANE_W = $bits(lane_t);

    lane_t lane_v [ROWS][COLS];
    fx_t   psum_h [ROWS][COLS+1];

    // column entry: lane c delayed by c cycles
    for (genvar c = 0; c < COLS; c++) begin : g_col
        lane_t lane_src;
        assign lane_src = '{data: in_x[c*DATA_W +: DATA_W], bank: in_bank, vld: in_valid};
        if (c == 0) begin : g_direct
            assign lane_v[0][c] = lane_src;
        end else begin : g_skew
            wsys_delay #(.W(LANE_W), .DEPTH(c)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (lane_src),
                .dout (lane_v[0][c])
            );
        end
    end

    // row entry: bias r delayed by r cycles; row exit deskew
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == 0) begin : g_bias_direct
            assign psum_h[r][0] = in_bias[r*DATA_W +: DATA_W];
        end else begin : g_bias_skew
            wsys_delay #(.W(DATA_W), .DEPTH(r)) u_bskew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (in_bias[r*DATA_W +: DATA_W]),
                .dout (psum_h[r][0])
            );
        end

        if (r == ROWS - 1) begin : g_out_direct
            assign out_y[r*DATA_W +: DATA_W] = psum_h[r][COLS];
        end else begin : g_out_deskew
            wsys_delay #(.W(DATA_W), .DEPTH(ROWS - 1 - r)) u_dskew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (psum_h[r][COLS]),
                .dout (out_y[r*DATA_W +: DATA_W])
            );
        end

        for (genvar c = 0; c < COLS; c++) begin : g_pe
            logic hit;
            assign hit = ld_en && (ld_row == ROW_W'(r)) && (ld_col == COL_W'(c));

            wsys_pe u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (hit),
                .wr_bank(ld_bank),
                .wr_data(ld_data),
                .lane_i (lane_v[r][c]),
                .psum_i (psum_h[r][c]),
                .psum_o (psum_h[r][c+1])
            );

            if (r < ROWS - 1) begin : g_down
                wsys_delay #(.W(LANE_W), .DEPTH(1)) u_lane (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  (lane_v[r][c]),
                    .dout (lane_v[r+1][c])
                );
            end
        end
    end

    // valid leaves with the last column's word below the bottom row
    wsys_delay #(.W(1), .DEPTH(1)) u_vld_out (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lane_v[ROWS-1][COLS-1].vld),
        .dout (out_valid)
    );
endmodule

// File: rtl/wsys_array_chk.sv
`timescale 1ns/1ps
module wsys_array_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 16,
    parameter int DW   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic [ROWS*DW-1:0] out_y
);
    localparam int LAT   = ROWS + COLS - 1;
    localparam int CNT_W = $clog2(LAT + 2) + 1;

    // cycles since the most recent accepted vector, saturating past LAT
    logic [CNT_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (in_valid)                      gap_d = CNT_W'(1);
        else if (gap_q < CNT_W'(LAT + 1))  gap_d = gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= CNT_W'(LAT + 1);
        else        gap_q <= gap_d;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_y == '0));

    assert_result_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == CNT_W'(LAT)) |-> out_valid);

    assert_no_stray_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q > CNT_W'(LAT)) |-> !out_valid);

    assert_result_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_y));
endmodule

bind wsys_array wsys_array_chk #(.ROWS(ROWS), .COLS(COLS), .DW(wsys_pkg::DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_y    (out_y)
);

// File: tb/tb_wsys_array.sv
`timescale 1ns/1ps
module tb_wsys_array;
    localparam int ROWS  = 4;
    localparam int COLS  = 8;
    localparam int ROW_W = 2;
    localparam int COL_W = 3;
    localparam int LAT   = ROWS + COLS - 1;
    localparam int QMAX  = 512;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ld_en = 1'b0;
    logic [1:0]           ld_bank = '0;
    logic [ROW_W-1:0]     ld_row = '0;
    logic [COL_W-1:0]     ld_col = '0;
    logic [15:0]          ld_data = '0;
    logic                 in_valid = 1'b0;
    logic [1:0]           in_bank = '0;
    logic [COLS*16-1:0]   in_x = '0;
    logic [ROWS*16-1:0]   in_bias = '0;
    logic                 out_valid;
    logic [ROWS*16-1:0]   out_y;

    wsys_array #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_bank(ld_bank), .ld_row(ld_row),
        .ld_col(ld_col), .ld_data(ld_data), .in_valid(in_valid), .in_bank(in_bank),
        .in_x(in_x), .in_bias(in_bias), .out_valid(out_valid), .out_y(out_y)
    );

    always #2.5 clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 0;
    int    wmod [0:3][0:ROWS-1][0:COLS-1];
    int    expv [0:QMAX-1][0:ROWS-1];
    int    due  [0:QMAX-1];
    string tag  [0:QMAX-1];
    int    wr_p = 0;
    int    rd_p = 0;

    function automatic int clip16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int qmul(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = (p + 1024) >>> 11;
        return clip16(p);
    endfunction

    function automatic int rnd(int span);
        return int'($urandom_range(2 * span, 0)) - span;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic scoreboard();
        if (out_valid) begin
            if (rd_p == wr_p) begin
                chk(1'b0, "R4", "valid with nothing outstanding", 1, 0);
            end else begin
                chk(cyc == due[rd_p], "R4", "result cycle", cyc, due[rd_p]);
                for (int r = 0; r < ROWS; r++) begin
                    int act;
                    act = int'($signed(out_y[r*16 +: 16]));
                    chk(act == expv[rd_p][r], tag[rd_p],
                        $sformatf("vector %0d row %0d", rd_p, r), act, expv[rd_p][r]);
                end
                rd_p++;
            end
        end else if (rd_p != wr_p && cyc >= due[rd_p]) begin
            chk(1'b0, "R4", "valid missing", 0, 1);
            rd_p++;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (rst_n) scoreboard();
        ld_en    = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic put_w(int b, int r, int c, int v);
        ld_en   = 1'b1;
        ld_bank = 2'(b);
        ld_row  = ROW_W'(r);
        ld_col  = COL_W'(c);
        ld_data = 16'(v);
        wmod[b][r][c] = v;
    endtask

    task automatic put_vec(int b, int xv[COLS], int bv[ROWS], string req);
        int acc;
        in_valid = 1'b1;
        in_bank  = 2'(b);
        for (int c = 0; c < COLS; c++) in_x[c*16 +: 16] = 16'(xv[c]);
        for (int r = 0; r < ROWS; r++) begin
            in_bias[r*16 +: 16] = 16'(bv[r]);
            acc = bv[r];
            for (int c = 0; c < COLS; c++) acc = clip16(longint'(acc) + qmul(xv[c], wmod[b][r][c]));
            expv[wr_p][r] = acc;
        end
        due[wr_p] = cyc + LAT;
        tag[wr_p] = req;
        wr_p++;
    endtask

    task automatic fill_bank(int b, int span);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                put_w(b, r, c, (span == 0) ? 0 : rnd(span));
                tick();
            end
    endtask

    initial begin
        int xv [COLS];
        int bv [ROWS];
        int s  [COLS+20];
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) wmod[b][r][c] = 0;

        // R1: reset state
        repeat (3) tick();
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(out_y == '0, "R1", "out_y in reset", int'(out_y[15:0]), 0);
        rst_n = 1'b1;
        tick();
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R1: caches start at zero, every bank returns the bias
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < COLS; c++) xv[c] = rnd(8000);
            for (int r = 0; r < ROWS; r++) bv[r] = rnd(20000);
            put_vec(b, xv, bv, "R1");
            tick();
        end
        repeat (LAT + 2) tick();

        // R7: load all four banks with random weights
        for (int b = 0; b < 4; b++) fill_bank(b, 4096);

        // R4: isolated vector, then silence
        for (int c = 0; c < COLS; c++) xv[c] = rnd(4096);
        for (int r = 0; r < ROWS; r++) bv[r] = rnd(2048);
        put_vec(0, xv, bv, "R4");
        tick();
        repeat (LAT + 8) tick();

        // R5 R6: back-to-back vectors rotating through the banks
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < COLS; c++) xv[c] = rnd(4096);
            for (int r = 0; r < ROWS; r++) bv[r] = rnd(4096);
            put_vec(i % 4, xv, bv, (i % 2 == 0) ? "R5" : "R6");
            tick();
        end
        repeat (LAT + 2) tick();

        // R9: zero data gives bias on every bank
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < COLS; c++) xv[c] = 0;
            for (int r = 0; r < ROWS; r++) bv[r] = rnd(30000);
            put_vec(b, xv, bv, "R9");
            tick();
        end

        // R2: rounding of half and near-half products in bank 3
        fill_bank(3, 0);
        put_w(3, 0, 0, 1024);  tick();
        put_w(3, 1, 0, 1023);  tick();
        put_w(3, 2, 0, -1024); tick();
        put_w(3, 3, 0, -1025); tick();
        for (int c = 0; c < COLS; c++) xv[c] = 0;
        for (int r = 0; r < ROWS; r++) bv[r] = 0;
        xv[0] = 1;  put_vec(3, xv, bv, "R2"); tick();
        xv[0] = -1; put_vec(3, xv, bv, "R2"); tick();
        xv[0] = 3;  put_vec(3, xv, bv, "R2"); tick();
        repeat (LAT + 2) tick();

        // R2 R3: product clipping and ordered clipped accumulation
        for (int c = 0; c < COLS; c++) begin
            put_w(3, 0, c, 32767);  tick();
            put_w(3, 1, c, -32768); tick();
            put_w(3, 2, c, (c == 0) ? 32767 : ((c == 1) ? -32768 : 0)); tick();
            put_w(3, 3, c, (c == 0) ? 32767 : ((c == 1) ? -8192 : 0)); tick();
        end
        for (int c = 0; c < COLS; c++) xv[c] = 32767;
        bv[0] = 0; bv[1] = 0; bv[2] = 0; bv[3] = 32767;
        put_vec(3, xv, bv, "R3"); tick();
        for (int c = 0; c < COLS; c++) xv[c] = -32768;
        bv[0] = -32768; bv[1] = 100; bv[2] = -5; bv[3] = -32768;
        put_vec(3, xv, bv, "R2"); tick();
        for (int c = 0; c < COLS; c++) xv[c] = 2048;
        bv[0] = 30000; bv[1] = -30000; bv[2] = 7; bv[3] = 32767;
        put_vec(3, xv, bv, "R3"); tick();
        repeat (LAT + 2) tick();

        // R8: sliding windows over a sequence with kernels in bank 1
        for (int k = 0; k < COLS + 20; k++) s[k] = rnd(6000);
        for (int r = 0; r < ROWS; r++) bv[r] = rnd(500);
        for (int k = 0; k < 20; k++) begin
            for (int c = 0; c < COLS; c++) xv[c] = s[k + c];
            put_vec(1, xv, bv, "R8");
            tick();
        end
        repeat (LAT + 2) tick();

        // R7: load bank 2 while bank 0 streams, then use both
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < COLS; c++) xv[c] = rnd(4096);
            for (int r = 0; r < ROWS; r++) bv[r] = rnd(4096);
            put_vec(0, xv, bv, "R7");
            put_w(2, i / COLS, i % COLS, rnd(8000));
            tick();
        end
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < COLS; c++) xv[c] = rnd(4096);
            for (int r = 0; r < ROWS; r++) bv[r] = rnd(4096);
            put_vec((i % 2 == 0) ? 2 : 0, xv, bv, "R7");
            tick();
        end
        repeat (LAT + 4) tick();
        chk(rd_p == wr_p, "R4", "results outstanding at end", rd_p, wr_p);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule